// File: doc/BRIEF.md
# Codec Volume Register Parallel Port

This block is the control side of a stereo audio codec. A host reaches a small bank of 6-bit volume registers over a 6-bit parallel data bus, using an active-low chip select, a register-select line, and active-low write and read strobes. Each access is two-phase. A write strobe with register select high stores a 5-bit register address. A later write strobe with register select low stores the data word in the addressed register. A read strobe puts the addressed register's word on the bus. Several such cycles may run back to back while chip select stays low.

Each stored word has two fields. Bit 5 is a mute flag. Bits 4..0 are an attenuation code in 1.5 dB steps, so code 0 is 0 dB and code 31 is -46.5 dB. For every register the block outputs the mute flag and the attenuation in half-dB units (code times 3), ready for the mixer paths downstream. It also drives an active-low enable and a direction line (high means read) for an external bus transceiver. The bus is split into input, output and output-enable, so the pad tristate sits outside the block.

Top module: `codec_vol_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register loads 6'b100000 (mute set, code 0). After reset, every `mute_o` bit reads 1, every attenuation field reads 0, `xcvr_en_n` is 1, `xcvr_dir` is 0 and `data_oe` is 0.
- R2: A falling edge on `wr_n` with `cs_n` low and `rsel` high latches `data_i[4:0]` as the current address. A falling edge on `wr_n` with `cs_n` low and `rsel` low stores all six bits of `data_i` in the register at the current address.
- R3: While `cs_n` and `rd_n` are both low, `data_oe` is 1 and `data_o` shows, in the same cycle, the word stored at the current address.
- R4: Valid addresses are 0 to 18. A data write to address 19 or above changes no register, and a read from such an address returns 0.
- R5: `data_oe` is 0 whenever `cs_n` or `rd_n` is high.
- R6: Strobes seen while `cs_n` is high change neither the address nor any register.
- R7: `mute_o[i]` equals bit 5 of register i, and it follows a write at the second rising edge after the strobe's falling edge is sampled.
- R8: Field i of `atten_o` (bits i*7+6 .. i*7) equals bits 4..0 of register i times 3, whatever the mute bit is. It updates with the same timing as R7.
- R9: One cycle after a cycle in which `cs_n` is low and either strobe is low, `xcvr_en_n` is 0. `xcvr_dir` is 1 one cycle after a cycle in which `cs_n` and `rd_n` are both low, and 0 otherwise.
- R10: With `cs_n` held low, each new strobe edge is a separate access. The address stays the same between data accesses.
- R11: A strobe held low for several cycles counts as a single access. It takes the data present in its first low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rsel | input | 1 | High: a write strobe carries an address; low: it carries data |
| wr_n | input | 1 | Write strobe, active low, edge-detected |
| rd_n | input | 1 | Read strobe, active low |
| data_i | input | 6 | Bus value from the host |
| data_o | output | 6 | Bus value to the host, valid while data_oe is high |
| data_oe | output | 1 | High while the block drives the bus |
| xcvr_en_n | output | 1 | Registered enable for the external transceiver, active low |
| xcvr_dir | output | 1 | Registered transceiver direction, 1 = read |
| mute_o | output | 19 | Registered mute flag per register |
| atten_o | output | 133 | Registered attenuation per register in half-dB units, 7 bits each |

## Verification
The assertions take for granted that every bus input changes synchronously to `clk` and that `rsel` and `data_i` are already valid in the cycle in which a strobe first goes low. This covers the setup and hold rules of the host protocol. The bench changes every input only on falling clock edges. It sets `rsel` and `data_i` in the same step that lowers a strobe and keeps them for the whole low phase, except in the R11 test, which changes `data_i` on purpose during a strobe held low. The bench also sweeps all 32 addresses and all 64 words through a reference model that computes the results arithmetically.

// File: rtl/cvp_pkg.sv
package cvp_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_ADDR  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic int unsigned att_width(input int unsigned code_w);
    return $clog2(((2 ** code_w) - 1) * 3 + 1);
  endfunction
endpackage

// File: rtl/cvp_strobe.sv
module cvp_strobe
  import cvp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rsel,
  input  logic wr_n,
  output acc_e acc
);
  logic wr_prev_q;
  logic wr_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_prev_q <= 1'b1;
    else        wr_prev_q <= wr_n;
  end

  assign wr_fall = wr_prev_q & ~wr_n;

  always_comb begin
    acc = ACC_NONE;
    if (!cs_n && wr_fall) acc = rsel ? ACC_ADDR : ACC_WRITE;
  end
endmodule

// File: rtl/cvp_regbank.sv
module cvp_regbank
  import cvp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 19,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CODE_W   = 5,
  localparam int unsigned DATA_W  = CODE_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  acc_e                         acc,
  input  logic [DATA_W-1:0]            data_i,
  output logic [ADDR_W-1:0]            addr_q,
  output logic [DATA_W-1:0]            rd_word,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);
  localparam logic [DATA_W-1:0] RST_WORD = {1'b1, {CODE_W{1'b0}}};

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              addr_ok;

  assign addr_ok = (32'(addr_q) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= RST_WORD;
    end else begin
      case (acc)
        ACC_ADDR:  addr_q <= data_i[ADDR_W-1:0];
        ACC_WRITE: if (addr_ok) regs_q[addr_q] <= data_i;
        default:   ;
      endcase
    end
  end

  assign rd_word = addr_ok ? regs_q[addr_q] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end
endmodule

// File: rtl/cvp_gain_map.sv
module cvp_gain_map #(
  parameter int unsigned NUM_REGS = 19,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned ATT_W    = 7,
  localparam int unsigned DATA_W  = CODE_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_REGS*DATA_W-1:0]  regs_flat,
  output logic [NUM_REGS-1:0]         mute_o,
  output logic [NUM_REGS*ATT_W-1:0]   atten_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_path
    logic [CODE_W-1:0] code;
    logic [ATT_W-1:0]  half_db;

    assign code    = regs_flat[g*DATA_W +: CODE_W];
    assign half_db = ATT_W'({code, 1'b0}) + ATT_W'(code);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mute_o[g]                 <= 1'b1;
        atten_o[g*ATT_W +: ATT_W] <= '0;
      end else begin
        mute_o[g]                 <= regs_flat[g*DATA_W + CODE_W];
        atten_o[g*ATT_W +: ATT_W] <= half_db;
      end
    end
  end
endmodule

// File: rtl/cvp_xcvr_ctl.sv
module cvp_xcvr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic xcvr_en_n,
  output logic xcvr_dir
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcvr_en_n <= 1'b1;
      xcvr_dir  <= 1'b0;
    end else begin
      xcvr_en_n <= ~(~cs_n & (~rd_n | ~wr_n));
      xcvr_dir  <= ~cs_n & ~rd_n;
    end
  end
endmodule

// File: rtl/codec_vol_port.sv
module codec_vol_port
  import cvp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 19,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CODE_W   = 5,
  localparam int unsigned DATA_W  = CODE_W + 1,
  localparam int unsigned ATT_W   = att_width(CODE_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       rsel,
  input  logic                       wr_n,
  input  logic                       rd_n,
  input  logic [DATA_W-1:0]          data_i,
  output logic [DATA_W-1:0]          data_o,
  output logic                       data_oe,
  output logic                       xcvr_en_n,
  output logic                       xcvr_dir,
  output logic [NUM_REGS-1:0]        mute_o,
  output logic [NUM_REGS*ATT_W-1:0]  atten_o
);
  acc_e                        acc;
  logic [ADDR_W-1:0]           addr_q;
  logic [DATA_W-1:0]           rd_word;
  logic [NUM_REGS*DATA_W-1:0]  regs_flat;

  cvp_strobe strobe_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .rsel  (rsel),
    .wr_n  (wr_n),
    .acc   (acc)
  );

  cvp_regbank #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .CODE_W   (CODE_W)
  ) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .data_i    (data_i),
    .addr_q    (addr_q),
    .rd_word   (rd_word),
    .regs_flat (regs_flat)
  );

  cvp_gain_map #(
    .NUM_REGS (NUM_REGS),
    .CODE_W   (CODE_W),
    .ATT_W    (ATT_W)
  ) gain_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .regs_flat (regs_flat),
    .mute_o    (mute_o),
    .atten_o   (atten_o)
  );

  cvp_xcvr_ctl xcvr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .xcvr_en_n (xcvr_en_n),
    .xcvr_dir  (xcvr_dir)
  );

  assign data_oe = ~cs_n & ~rd_n;
  assign data_o  = data_oe ? rd_word : '0;
endmodule

// File: rtl/codec_vol_port_chk.sv
module codec_vol_port_chk #(
  parameter int unsigned NUM_REGS = 19,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                wr_n,
  input logic                rd_n,
  input logic [DATA_W-1:0]   data_o,
  input logic                data_oe,
  input logic                xcvr_en_n,
  input logic                xcvr_dir,
  input logic [NUM_REGS-1:0] mute_o,
  input logic [ADDR_W-1:0]   addr_q
);
  a_r9_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (!rd_n || !wr_n)) |=> !xcvr_en_n);

  a_r9_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n) |=> xcvr_dir);

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (xcvr_en_n && !xcvr_dir));

  a_r4_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && (32'(addr_q) >= NUM_REGS)) |-> (data_o == '0));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(addr_q));

  a_r6_mute_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ##1 $stable(mute_o));
endmodule

bind codec_vol_port codec_vol_port_chk #(
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .wr_n      (wr_n),
  .rd_n      (rd_n),
  .data_o    (data_o),
  .data_oe   (data_oe),
  .xcvr_en_n (xcvr_en_n),
  .xcvr_dir  (xcvr_dir),
  .mute_o    (mute_o),
  .addr_q    (addr_q)
);

// File: tb/codec_vol_port_tb_top.sv
`timescale 1ns/1ps
module codec_vol_port_tb_top;
  localparam int NR = 19;
  localparam int AW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cs_n = 1'b1;
  logic            rsel = 1'b0;
  logic            wr_n = 1'b1;
  logic            rd_n = 1'b1;
  logic [5:0]      data_i = '0;
  logic [5:0]      data_o;
  logic            data_oe;
  logic            xcvr_en_n;
  logic            xcvr_dir;
  logic [NR-1:0]   mute_o;
  logic [NR*AW-1:0] atten_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [5:0] model [NR];

  always #10 clk = ~clk;

  codec_vol_port dut_i (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rsel (rsel),
    .wr_n (wr_n), .rd_n (rd_n), .data_i (data_i), .data_o (data_o),
    .data_oe (data_oe), .xcvr_en_n (xcvr_en_n), .xcvr_dir (xcvr_dir),
    .mute_o (mute_o), .atten_o (atten_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_addr(input int a);
    @(negedge clk) rsel = 1'b1; data_i = 6'(a); wr_n = 1'b0;
    @(negedge clk) wr_n = 1'b1; rsel = 1'b0;
  endtask

  task automatic strobe_data(input int v);
    @(negedge clk) rsel = 1'b0; data_i = 6'(v); wr_n = 1'b0;
    @(negedge clk);
    chk("R9 write en_n", int'(xcvr_en_n), 0);
    chk("R9 write dir", int'(xcvr_dir), 0);
    wr_n = 1'b1;
  endtask

  task automatic write_reg(input int a, input int v);
    @(negedge clk) cs_n = 1'b0;
    strobe_addr(a);
    strobe_data(v);
    if (a < NR) model[a] = 6'(v);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_cur(output int v);
    @(negedge clk) rd_n = 1'b0;
    #2;
    chk("R3 oe during read", int'(data_oe), 1);
    v = int'(data_o);
    @(negedge clk);
    chk("R9 read dir", int'(xcvr_dir), 1);
    chk("R9 read en_n", int'(xcvr_en_n), 0);
    rd_n = 1'b1;
  endtask

  task automatic read_reg(input int a, output int v);
    @(negedge clk) cs_n = 1'b0;
    strobe_addr(a);
    read_cur(v);
    @(negedge clk) cs_n = 1'b1;
  endtask

  task automatic check_outputs(input string req);
    for (int i = 0; i < NR; i++) begin
      chk({req, " mute"}, int'(mute_o[i]), int'(model[i][5]));
      chk({req, " atten"}, int'(atten_o[i*AW +: AW]), int'(model[i][4:0]) * 3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    for (int i = 0; i < NR; i++) model[i] = 6'b100000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_outputs("R1");
    chk("R1 en_n", int'(xcvr_en_n), 1);
    chk("R1 dir", int'(xcvr_dir), 0);
    chk("R1 oe", int'(data_oe), 0);

    // R2 R4 R7 R8: write every address 0..31
    for (int a = 0; a < 32; a++) write_reg(a, (a * 5 + 3) & 63);
    check_outputs("R2 R4 R7 R8 sweep");
    for (int a = 0; a < 32; a++) begin
      read_reg(a, v);
      if (a < NR) chk("R3 readback", v, int'(model[a]));
      else        chk("R4 out-of-range read", v, 0);
    end

    // R7 R8: all 64 words through register 17
    for (int w = 0; w < 64; w++) begin
      write_reg(17, w);
      chk("R7 mute map", int'(mute_o[17]), w >> 5);
      chk("R8 atten map", int'(atten_o[17*AW +: AW]), (w & 31) * 3);
    end

    // R5: no drive without both cs_n and rd_n low
    @(negedge clk) cs_n = 1'b0; rd_n = 1'b1;
    #2 chk("R5 cs low rd high", int'(data_oe), 0);
    @(negedge clk) cs_n = 1'b1; rd_n = 1'b0;
    #2 chk("R5 cs high rd low", int'(data_oe), 0);
    @(negedge clk);
    chk("R9 idle dir", int'(xcvr_dir), 0);
    chk("R9 idle en_n", int'(xcvr_en_n), 1);
    rd_n = 1'b1;

    // R6: strobes with cs_n high are ignored
    write_reg(4, 6'h0A);
    strobe_addr(3);
    @(negedge clk) data_i = 6'h00; wr_n = 1'b0;
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk);
    check_outputs("R6 ignored strobes");
    @(negedge clk) cs_n = 1'b0;
    read_cur(v);
    chk("R6 address kept", v, int'(model[4]));
    @(negedge clk) cs_n = 1'b1;

    // R10: burst with cs_n held low
    @(negedge clk) cs_n = 1'b0;
    strobe_addr(5);  strobe_data(6'h11); model[5] = 6'h11;
    strobe_data(6'h12); model[5] = 6'h12;
    strobe_addr(6);  strobe_data(6'h2A); model[6] = 6'h2A;
    strobe_addr(5);  read_cur(v);
    chk("R10 burst reg5", v, 6'h12);
    strobe_addr(6);  read_cur(v);
    chk("R10 burst reg6", v, 6'h2A);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    check_outputs("R10 burst");

    // R11: held-low strobe is one access taking first data
    @(negedge clk) cs_n = 1'b0;
    strobe_addr(7);
    @(negedge clk) data_i = 6'h05; wr_n = 1'b0;
    @(negedge clk) data_i = 6'h3F;
    @(negedge clk) data_i = 6'h21;
    @(negedge clk) wr_n = 1'b1;
    model[7] = 6'h05;
    read_cur(v);
    chk("R11 held strobe", v, 6'h05);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    check_outputs("R11 outputs");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule